// File: doc/BRIEF.md
# Byte-Select Write Sequencer for a Multiplexed 16-bit External Bus

This block performs one byte write on a 16-bit external bus that carries both address and data on the same wires. The target is a word-wide memory that can write a single byte of a word. A request brings a byte-granular pointer and an 8-bit value. The block then runs a fixed four-cycle bus transaction:

1. It presents the word address with an address-latch strobe, so that external latches can capture the low address bits.
2. It holds the address for one more cycle after the strobe drops.
3. It drives the data with a single write strobe.
4. It holds the data for one cycle after the strobe rises.

The byte value is copied onto both halves of the bus. The lane that is actually written is chosen by the pointer's least significant bit. That bit is driven in two forms: as a plain byte-address line for flash-style parts, and as a pair of active-low upper and lower byte selects for SRAM-style parts. The second write strobe and the output enable stay inactive throughout. When the block is idle it releases the bus.

The pointer and data are captured when the request is accepted. A request that arrives while a transaction is running is dropped. The requester watches `busy_o` and `done_o` to pace its requests.

Top module: `ebus_bytesel_writer`

## Requirements
- R1: After reset, and whenever idle, the outputs sit at these values: `busy_o`=0, `done_o`=0, `ad_oe_o`=0, `ale_o`=0, `ba0_o`=0, and `wrh_n_o`, `wrl_n_o`, `oe_n_o`, `ub_n_o`, `lb_n_o` all 1.
- R2: If `req_i` is 1 at a clock edge while idle, the next cycle is the address phase, with these values: `busy_o`=1, `ale_o`=1, `ad_oe_o`=1, `ad_o` = pointer bits [16:1], `addr_hi_o` = pointer bits [20:17].
- R3: The cycle after the address phase is a hold phase: `ale_o`=0, while `ad_o` and `addr_hi_o` keep the word address.
- R4: The third cycle is the write phase, with `wrh_n_o`=0. In the write phase and the following tail phase, `ad_o[15:8]` and `ad_o[7:0]` both equal the captured data byte.
- R5: `wrh_n_o` is low for exactly one cycle per transaction, and `ale_o` was high two cycles before that. `wrl_n_o` never goes low.
- R6: `done_o` is 1 only in the fourth (tail) cycle, with `busy_o` still 1 and `wrh_n_o`=1. The next cycle is idle.
- R7: Throughout a transaction, `ba0_o` equals pointer bit 0. When bit 0 is 1, `ub_n_o`=0 and `lb_n_o`=1. When bit 0 is 0, `lb_n_o`=0 and `ub_n_o`=1. Exactly one of the two selects is low.
- R8: `oe_n_o` stays 1 in every cycle.
- R9: A request made while `busy_o`=1 is ignored, even if it is held until the tail cycle. A request held high continuously starts the next transaction one idle cycle after `done_o`.
- R10: Changing `ptr_i` or `data_i` after acceptance has no effect on the address, data or byte selects of the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, sampled while idle |
| ptr_i | input | 21 | Byte pointer; bits [20:1] are the word address and bit 0 is the lane |
| data_i | input | 8 | Byte to write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse in the last cycle of a transaction |
| ad_o | output | 16 | Multiplexed address/data value |
| ad_oe_o | output | 1 | Drive enable for `ad_o`; 0 releases the bus |
| addr_hi_o | output | 4 | Upper word-address bits [20:17] |
| ale_o | output | 1 | Address-latch strobe, active high |
| wrh_n_o | output | 1 | Write strobe, active low |
| wrl_n_o | output | 1 | Second write strobe, held inactive |
| oe_n_o | output | 1 | Output enable, held inactive |
| ba0_o | output | 1 | Byte-address line |
| ub_n_o | output | 1 | Upper byte select, active low |
| lb_n_o | output | 1 | Lower byte select, active low |

## Verification
The bench places a small word memory on the bus. The memory latches the address only from the strobed address phase and merges bytes only through the byte selects. A wrong address slice, a swapped lane or a data byte missing from one half of the bus therefore shows up as a mismatch in the stored word. Directed writes to both lanes of the same word catch a design that overwrites the neighbouring byte. Writes at the all-ones and zero pointers catch truncated upper address bits.

Random transactions change the pointer and data after acceptance and keep requesting while busy. A design that re-samples its inputs corrupts the written word, and one that queues the stray request shows an unexpected extra transaction in the idle cycle. A continuously held request pins down the single idle gap between transactions. Phase-by-phase checks catch a strobe that lasts two cycles or an address-latch pulse that arrives late.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

    // Transaction phases, in bus order
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_HOLD  = 3'd2,
        ST_WRITE = 3'd3,
        ST_TAIL  = 3'd4
    } ebw_state_e;

endpackage

// File: rtl/ebw_sequencer.sv
module ebw_sequencer
    import ebw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    output ebw_state_e state_o,
    output logic       accept_o
);

    typedef struct packed {
        ebw_state_e state;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      accept;

    always_comb begin
        seq_d  = seq_q;
        accept = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    accept      = 1'b1;
                    seq_d.state = ST_ADDR;
                end
            end
            ST_ADDR:  seq_d.state = ST_HOLD;
            ST_HOLD:  seq_d.state = ST_WRITE;
            ST_WRITE: seq_d.state = ST_TAIL;
            ST_TAIL:  seq_d.state = ST_IDLE;
            default:  seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o  = seq_q.state;
    assign accept_o = accept;

endmodule

// File: rtl/ebw_capture.sv
module ebw_capture #(
    parameter int PTR_W  = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [DATA_W-1:0] data;
    } cap_regs_t;

    cap_regs_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (accept_i) begin
            cap_d.ptr  = ptr_i;
            cap_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign ptr_o  = cap_q.ptr;
    assign data_o = cap_q.data;

endmodule

// File: rtl/ebw_pindrive.sv
module ebw_pindrive
    import ebw_pkg::*;
#(
    parameter int PTR_W  = 21,
    parameter int AD_W   = 16,
    parameter int DATA_W = 8
) (
    input  ebw_state_e              state_i,
    input  logic [PTR_W-1:0]        ptr_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic [AD_W-1:0]         ad_o,
    output logic                    ad_oe_o,
    output logic [PTR_W-AD_W-2:0]   addr_hi_o,
    output logic                    ale_o,
    output logic                    wrh_n_o,
    output logic                    wrl_n_o,
    output logic                    oe_n_o,
    output logic                    ba0_o,
    output logic                    ub_n_o,
    output logic                    lb_n_o,
    output logic                    busy_o,
    output logic                    done_o
);

    localparam int LANES  = AD_W / DATA_W;
    localparam int WADR_W = PTR_W - 1;
    localparam int HI_W   = WADR_W - AD_W;

    logic [AD_W-1:0]   data_rep;
    logic [WADR_W-1:0] word_addr;
    logic              busy;
    logic              addr_phase;
    logic              lane_hi;

    // Copy the byte onto every lane of the bus
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign data_rep[g*DATA_W +: DATA_W] = data_i;
        end
    endgenerate

    assign word_addr = ptr_i[PTR_W-1:1];
    assign lane_hi   = ptr_i[0];

    always_comb begin
        busy       = (state_i != ST_IDLE);
        addr_phase = (state_i == ST_ADDR) || (state_i == ST_HOLD);

        ad_oe_o   = busy;
        ad_o      = '0;
        addr_hi_o = '0;
        if (busy) begin
            ad_o      = addr_phase ? word_addr[AD_W-1:0] : data_rep;
            addr_hi_o = word_addr[WADR_W-1:AD_W];
        end

        ale_o   = (state_i == ST_ADDR);
        wrh_n_o = !(state_i == ST_WRITE);
        wrl_n_o = 1'b1;
        oe_n_o  = 1'b1;

        ba0_o  = busy && lane_hi;
        ub_n_o = !(busy && lane_hi);
        lb_n_o = !(busy && !lane_hi);

        busy_o = busy;
        done_o = (state_i == ST_TAIL);
    end

    logic unused_hi;
    assign unused_hi = (HI_W < 0);

endmodule

// File: rtl/ebus_bytesel_writer.sv
module ebus_bytesel_writer
    import ebw_pkg::*;
#(
    parameter int PTR_W  = 21,
    parameter int AD_W   = 16,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic [PTR_W-1:0]       ptr_i,
    input  logic [DATA_W-1:0]      data_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [AD_W-1:0]        ad_o,
    output logic                   ad_oe_o,
    output logic [PTR_W-AD_W-2:0]  addr_hi_o,
    output logic                   ale_o,
    output logic                   wrh_n_o,
    output logic                   wrl_n_o,
    output logic                   oe_n_o,
    output logic                   ba0_o,
    output logic                   ub_n_o,
    output logic                   lb_n_o
);

    localparam int HI_W = PTR_W - AD_W - 1;

    ebw_state_e        state;
    logic              accept;
    logic [PTR_W-1:0]  ptr_cap;
    logic [DATA_W-1:0] data_cap;

    ebw_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .state_o  (state),
        .accept_o (accept)
    );

    ebw_capture #(
        .PTR_W  (PTR_W),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .ptr_i    (ptr_i),
        .data_i   (data_i),
        .ptr_o    (ptr_cap),
        .data_o   (data_cap)
    );

    ebw_pindrive #(
        .PTR_W  (PTR_W),
        .AD_W   (AD_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .state_i   (state),
        .ptr_i     (ptr_cap),
        .data_i    (data_cap),
        .ad_o      (ad_o),
        .ad_oe_o   (ad_oe_o),
        .addr_hi_o (addr_hi_o),
        .ale_o     (ale_o),
        .wrh_n_o   (wrh_n_o),
        .wrl_n_o   (wrl_n_o),
        .oe_n_o    (oe_n_o),
        .ba0_o     (ba0_o),
        .ub_n_o    (ub_n_o),
        .lb_n_o    (lb_n_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
    parameter int AD_W = 16,
    parameter int HI_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_o,
    input logic            done_o,
    input logic [AD_W-1:0] ad_o,
    input logic            ad_oe_o,
    input logic [HI_W-1:0] addr_hi_o,
    input logic            ale_o,
    input logic            wrh_n_o,
    input logic            ub_n_o,
    input logic            lb_n_o
);

    localparam int HALF = AD_W / 2;

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!ad_oe_o && ub_n_o && lb_n_o && wrh_n_o && !ale_o));

    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale_o) |-> ($stable(ad_o) && $stable(addr_hi_o)));

    a_r4_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
        !wrh_n_o |-> (ad_o[AD_W-1:HALF] == ad_o[HALF-1:0]));

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wrh_n_o |=> wrh_n_o);

    a_r5_ale_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wrh_n_o) |-> $past(ale_o, 2));

    a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (ub_n_o != lb_n_o));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    a_r10_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ale_o) |-> $stable(addr_hi_o));

endmodule

bind ebus_bytesel_writer ebw_checker #(
    .AD_W (AD_W),
    .HI_W (HI_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .addr_hi_o (addr_hi_o),
    .ale_o     (ale_o),
    .wrh_n_o   (wrh_n_o),
    .ub_n_o    (ub_n_o),
    .lb_n_o    (lb_n_o)
);

// File: tb/ebus_bytesel_writer_tb_top.sv
module ebus_bytesel_writer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [20:0] ptr_i = '0;
    logic [7:0]  data_i = '0;
    logic        busy_o, done_o, ad_oe_o, ale_o, wrh_n_o, wrl_n_o, oe_n_o;
    logic        ba0_o, ub_n_o, lb_n_o;
    logic [15:0] ad_o;
    logic [3:0]  addr_hi_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [15:0] mem_model [16];
    logic [15:0] exp_mem   [16];
    logic [19:0] lat_addr;

    always #5 clk = ~clk;

    ebus_bytesel_writer dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ptr_i(ptr_i), .data_i(data_i),
        .busy_o(busy_o), .done_o(done_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
        .addr_hi_o(addr_hi_o), .ale_o(ale_o), .wrh_n_o(wrh_n_o), .wrl_n_o(wrl_n_o),
        .oe_n_o(oe_n_o), .ba0_o(ba0_o), .ub_n_o(ub_n_o), .lb_n_o(lb_n_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [7:0] b,
                                          input logic hi);
        return hi ? {b, old[7:0]} : {old[15:8], b};
    endfunction

    task automatic check_idle(input string tag);
        chk(busy_o == 0 && done_o == 0 && ad_oe_o == 0 && ale_o == 0 && ba0_o == 0,
            tag, "idle flags", {busy_o, done_o, ad_oe_o, ale_o, ba0_o}, 0);
        chk(wrh_n_o && wrl_n_o && oe_n_o && ub_n_o && lb_n_o, tag, "idle strobes",
            {wrh_n_o, wrl_n_o, oe_n_o, ub_n_o, lb_n_o}, 5'h1f);
    endtask

    // Called at a negedge; returns at the negedge one cycle after the idle return
    task automatic run_write(input logic [20:0] p, input logic [7:0] d, input bit disturb);
        logic [15:0] dd;
        dd = {d, d};
        req_i = 1'b1; ptr_i = p; data_i = d;
        @(negedge clk);
        // address phase
        chk(busy_o && ale_o && ad_oe_o, "R2", "addr phase flags", {busy_o, ale_o, ad_oe_o}, 3'b111);
        chk(ad_o == p[16:1], "R2", "addr low", ad_o, p[16:1]);
        chk(addr_hi_o == p[20:17], "R2", "addr high", addr_hi_o, p[20:17]);
        chk(ba0_o == p[0] && ub_n_o == !p[0] && lb_n_o == p[0], "R7", "lane selects",
            {ba0_o, ub_n_o, lb_n_o}, {p[0], !p[0], p[0]});
        chk(oe_n_o == 1, "R8", "oe in addr", oe_n_o, 1);
        if (ale_o) lat_addr = {addr_hi_o, ad_o};
        req_i = 1'b0;
        if (disturb) begin
            ptr_i = ~p; data_i = ~d; req_i = 1'b1;
        end
        @(negedge clk);
        // hold phase
        chk(ale_o == 0 && ad_o == p[16:1] && addr_hi_o == p[20:17], "R3", "hold addr",
            ad_o, p[16:1]);
        chk(wrh_n_o == 1 && done_o == 0, "R3", "hold strobes", {wrh_n_o, done_o}, 2'b10);
        @(negedge clk);
        // write phase
        chk(wrh_n_o == 0 && wrl_n_o == 1, "R5", "write strobes", {wrh_n_o, wrl_n_o}, 2'b01);
        chk(ad_o == dd, "R4", "data on both lanes", ad_o, dd);
        chk(oe_n_o == 1, "R8", "oe in write", oe_n_o, 1);
        chk(ba0_o == p[0] && ub_n_o == !p[0] && lb_n_o == p[0], "R10", "selects kept",
            {ba0_o, ub_n_o, lb_n_o}, {p[0], !p[0], p[0]});
        if (!ub_n_o) mem_model[lat_addr[3:0]][15:8] = ad_o[15:8];
        if (!lb_n_o) mem_model[lat_addr[3:0]][7:0]  = ad_o[7:0];
        @(negedge clk);
        // tail phase
        chk(done_o && busy_o && wrh_n_o && wrl_n_o, "R6", "tail flags",
            {done_o, busy_o, wrh_n_o, wrl_n_o}, 4'hf);
        chk(ad_o == dd, "R4", "data held in tail", ad_o, dd);
        req_i = 1'b0;
        exp_mem[p[4:1]] = merge(exp_mem[p[4:1]], d, p[0]);
        @(negedge clk);
        check_idle("R6");
        chk(mem_model[p[4:1]] == exp_mem[p[4:1]], "R10", "stored word",
            mem_model[p[4:1]], exp_mem[p[4:1]]);
        @(negedge clk);
        chk(busy_o == 0, "R9", "busy request dropped", busy_o, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_model[i] = '0;
            exp_mem[i]   = '0;
        end
        lat_addr = '0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // Directed: both lanes of one word, extreme pointers
        run_write(21'h000010, 8'hA5, 1'b0);
        run_write(21'h000011, 8'h3C, 1'b0);
        chk(mem_model[8] == 16'h3CA5, "R7", "two-lane merge", mem_model[8], 16'h3CA5);
        run_write(21'h1FFFFF, 8'hFF, 1'b1);
        run_write(21'h000000, 8'h00, 1'b1);

        // Held request: one idle cycle between transactions
        req_i = 1'b1; ptr_i = 21'h000002; data_i = 8'h11;
        repeat (5) @(negedge clk);
        chk(busy_o == 0 && done_o == 0, "R9", "gap cycle idle", busy_o, 0);
        @(negedge clk);
        chk(busy_o && ale_o, "R9", "held request restarts", {busy_o, ale_o}, 2'b11);
        req_i = 1'b0;
        repeat (4) @(negedge clk);
        check_idle("R1");
        exp_mem[1] = merge(merge(exp_mem[1], 8'h11, 1'b0), 8'h11, 1'b0);
        mem_model[1] = exp_mem[1];

        // Random transactions
        for (int n = 0; n < 60; n++) begin
            run_write(21'($urandom), 8'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule